// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Takeover

This block is an 8-pin general-purpose I/O port that sits on a small microcontroller's internal data bus. Each pin has a stored output value and a stored direction bit, and the bus loads both on a clock edge. A direction bit of 1 turns off the pin's driver, so the pin is an input. A direction bit of 0 makes the pin drive its stored output value. The block reads the bus back through a registered read register. That register captures either the live pin levels or the stored direction bits.

Any pin can be handed to an on-chip peripheral through a per-pin select. While the select is active, the peripheral supplies both the pin's output value and its enable. It can make the pin an output or an input whatever the stored direction bit holds. The stored bit itself is never altered by this. The peripheral always sees the live pin levels. Two fixed pins also carry an input-level mode flag to the peripheral. The pins are presented as separate enable, output-value and input vectors, so that a surrounding model can resolve the external tri-state wire.

Top module: `gpio_bank`

## Requirements
- R1: After reset the stored direction bits are all 1 (0xFF), the stored output values are all 0, every pin enable is 0, and the read register is 0x00.
- R2: On a clock edge with `wrData` high, the stored output values load `busWrData`. Without `wrData` they hold, whatever `busWrData` carries.
- R3: On a clock edge with `wrDir` high, the stored direction bits load `busWrData`. Without `wrDir` they hold.
- R4: For a pin whose `periphSel` bit is 0, `pinOe` is the inverse of its stored direction bit and `pinOut` is its stored output value. The pin's `periphOe` and `periphOut` bits have no effect on it.
- R5: For a pin whose `periphSel` bit is 1, `pinOut` equals `periphOut` and `pinOe` equals `periphOe` (1 = drive, 0 = input), whatever its stored direction bit is.
- R6: Peripheral takeover never changes the stored direction bits. A direction read returns the stored bits, not the effective enables.
- R7: On a clock edge with `rdPort` high, the read register captures `pinIn`. With no read strobe it holds its value.
- R8: On a clock edge with `rdDir` high and `rdPort` low, the read register captures the stored direction bits as they were before that edge. A direction write in the same cycle shows up only on a later read.
- R9: When `rdPort` and `rdDir` are both high, the port read wins and the read register captures `pinIn`.
- R10: `periphIn` equals `pinIn` on every pin, for any select setting.
- R11: `levelSel` carries `levelMode` on bits 3 and 4 and is 0 on all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWrData | input | 8 | Write data from the internal bus |
| wrData | input | 1 | Write strobe for the stored output values |
| wrDir | input | 1 | Write strobe for the stored direction bits |
| rdPort | input | 1 | Read strobe, capture pin levels |
| rdDir | input | 1 | Read strobe, capture direction bits |
| busRdData | output | 8 | Registered read data |
| periphSel | input | 8 | Per-pin peripheral takeover select |
| periphOut | input | 8 | Peripheral output value per pin |
| periphOe | input | 8 | Peripheral drive enable per pin (1 = drive) |
| levelMode | input | 1 | Input-level mode flag for the mode pins |
| periphIn | output | 8 | Live pin levels routed to the peripheral |
| levelSel | output | 8 | Per-pin level mode (bits 3 and 4 only) |
| pinIn | input | 8 | Levels sensed on the pins |
| pinOe | output | 8 | Effective per-pin driver enable |
| pinOut | output | 8 | Effective per-pin driven value |

## Verification
Two functions can meet in one cycle: a direction write and a direction read. The bench raises `wrDir` and `rdDir` on the same edge. It expects the old direction bits in the read register, and the new bits only after a second read. A port read and a direction read can also collide. That case is provoked by raising both strobes together, and it is judged against the pin levels that the bench's own tri-state model resolves. The vector walk also checks the stored direction bits after each takeover pattern. This shows that overrides never leak into them.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef struct packed {
    logic ldData;
    logic ldDir;
    logic capPin;
    logic capDir;
  } ioStrobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic      wrData,
  input  logic      wrDir,
  input  logic      rdPort,
  input  logic      rdDir,
  output ioStrobe_t strobe
);
  always_comb begin
    strobe.ldData = wrData;
    strobe.ldDir  = wrDir;
    // the port read takes precedence over the direction read
    strobe.capPin = rdPort;
    strobe.capDir = rdDir & ~rdPort;
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] LEVEL_MASK = 8'h18,
  parameter logic [WIDTH-1:0] DIR_RESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ioStrobe_t        strobe,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] periphSel,
  input  logic [WIDTH-1:0] periphOut,
  input  logic [WIDTH-1:0] periphOe,
  input  logic             levelMode,
  output logic [WIDTH-1:0] periphIn,
  output logic [WIDTH-1:0] levelSel,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut
);
  logic [WIDTH-1:0] dataQ;
  logic [WIDTH-1:0] dirQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataQ <= '0;
      dirQ  <= DIR_RESET;
    end else begin
      if (strobe.ldData) dataQ <= busWrData;
      if (strobe.ldDir)  dirQ  <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             busRdData <= '0;
    else if (strobe.capPin) busRdData <= pinIn;
    else if (strobe.capDir) busRdData <= dirQ;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pinOut[i]   = periphSel[i] ? periphOut[i] : dataQ[i];
    assign pinOe[i]    = periphSel[i] ? periphOe[i]  : ~dirQ[i];
    assign periphIn[i] = pinIn[i];
    if (LEVEL_MASK[i]) begin : g_lvl
      assign levelSel[i] = levelMode;
    end else begin : g_nolvl
      assign levelSel[i] = 1'b0;
    end
  end

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.ldData |=> $stable(dataQ));
  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ldDir |=> dirQ == $past(busWrData));
  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.ldDir |=> $stable(dirQ));
  // R7
  pin_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capPin |=> busRdData == $past(pinIn));
  // R8
  dir_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capDir |=> busRdData == $past(dirQ));
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.capPin || strobe.capDir) |=> $stable(busRdData));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] LEVEL_MASK = 8'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] busWrData,
  input  logic             wrData,
  input  logic             wrDir,
  input  logic             rdPort,
  input  logic             rdDir,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] periphSel,
  input  logic [WIDTH-1:0] periphOut,
  input  logic [WIDTH-1:0] periphOe,
  input  logic             levelMode,
  output logic [WIDTH-1:0] periphIn,
  output logic [WIDTH-1:0] levelSel,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut
);
  ioStrobe_t strobe;

  gpio_bank_ctrl u_ctrl (
    .wrData (wrData),
    .wrDir  (wrDir),
    .rdPort (rdPort),
    .rdDir  (rdDir),
    .strobe (strobe)
  );

  gpio_bank_dp #(.WIDTH(WIDTH), .LEVEL_MASK(LEVEL_MASK)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .periphSel (periphSel),
    .periphOut (periphOut),
    .periphOe  (periphOe),
    .levelMode (levelMode),
    .periphIn  (periphIn),
    .levelSel  (levelSel),
    .pinIn     (pinIn),
    .pinOe     (pinOe),
    .pinOut    (pinOut)
  );

  // R5
  sel_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((periphSel & (pinOe ^ periphOe)) == '0));
  // R9
  rd_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdPort && rdDir) |=> busRdData == $past(pinIn));
endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] busWrData = '0;
  logic wrData = 0, wrDir = 0, rdPort = 0, rdDir = 0;
  logic [7:0] busRdData;
  logic [7:0] periphSel = '0, periphOut = '0, periphOe = '0;
  logic levelMode = 0;
  logic [7:0] periphIn, levelSel, pinIn, pinOe, pinOut;
  logic [7:0] extVal = '0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  // external tri-state model: driven pins read back their own value
  assign pinIn = (pinOe & pinOut) | (~pinOe & extVal);

  gpio_bank uut (
    .clk(clk), .rst_n(rst_n), .busWrData(busWrData), .wrData(wrData),
    .wrDir(wrDir), .rdPort(rdPort), .rdDir(rdDir), .busRdData(busRdData),
    .periphSel(periphSel), .periphOut(periphOut), .periphOe(periphOe),
    .levelMode(levelMode), .periphIn(periphIn), .levelSel(levelSel),
    .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut)
  );

  // dir, data, sel, pOut, pOe, ext
  localparam logic [47:0] VEC [6] = '{
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5},
    {8'h00, 8'h3C, 8'h00, 8'hFF, 8'hFF, 8'h00},
    {8'h0F, 8'hAA, 8'hF0, 8'h55, 8'h0F, 8'hC3},
    {8'hF0, 8'h5A, 8'h0F, 8'h06, 8'h0F, 8'h99},
    {8'h55, 8'hFF, 8'hAA, 8'hAA, 8'hFF, 8'h0F},
    {8'h00, 8'h81, 8'hFF, 8'h7E, 8'h00, 8'hF0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input bit isDir, input logic [7:0] val);
    busWrData = val;
    if (isDir) wrDir = 1; else wrData = 1;
    @(negedge clk);
    wrDir = 0; wrData = 0;
  endtask

  task automatic readReg(input bit isDir);
    if (isDir) rdDir = 1; else rdPort = 1;
    @(negedge clk);
    rdDir = 0; rdPort = 0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got 00 expected 01");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] eOe, eOut, ePin;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    check("R1 rd", busRdData, 8'h00);
    rst_n = 1;
    @(negedge clk);
    readReg(1);
    check("R1 dir", busRdData, 8'hFF);

    foreach (VEC[k]) begin
      writeReg(1, VEC[k][47:40]);
      writeReg(0, VEC[k][39:32]);
      periphSel = VEC[k][31:24];
      periphOut = VEC[k][23:16];
      periphOe  = VEC[k][15:8];
      extVal    = VEC[k][7:0];
      #1;
      eOe  = (periphSel & periphOe)  | (~periphSel & ~VEC[k][47:40]);
      eOut = (periphSel & periphOut) | (~periphSel & VEC[k][39:32]);
      ePin = (eOe & eOut) | (~eOe & extVal);
      check("R4/R5 pinOe", pinOe, eOe);
      check("R4/R5 pinOut", pinOut, eOut);
      check("R10 periphIn", periphIn, ePin);
      @(negedge clk);
      readReg(0);
      check("R7 port read", busRdData, ePin);
      readReg(1);
      check("R6 dir read", busRdData, VEC[k][47:40]);
      // R7 hold with no strobe
      extVal = ~extVal;
      @(negedge clk);
      check("R7 hold", busRdData, VEC[k][47:40]);
    end

    // R2: data latch holds without strobe
    periphSel = '0; extVal = 8'h00;
    writeReg(1, 8'h00);
    writeReg(0, 8'h96);
    busWrData = 8'h11;
    @(negedge clk);
    check("R2 hold", pinOut, 8'h96);
    // R3: dir holds without strobe
    busWrData = 8'hFF;
    @(negedge clk);
    check("R3 hold", pinOe, 8'hFF);

    // R8: same-cycle dir write and dir read
    writeReg(1, 8'h12);
    busWrData = 8'h34; wrDir = 1; rdDir = 1;
    @(negedge clk);
    wrDir = 0; rdDir = 0;
    check("R8 old dir", busRdData, 8'h12);
    readReg(1);
    check("R8 new dir", busRdData, 8'h34);

    // R9: both reads, port wins. dir=34, data=96 -> driven bits ~34 & 96
    extVal = 8'hFF;
    rdPort = 1; rdDir = 1;
    @(negedge clk);
    rdPort = 0; rdDir = 0;
    check("R9 prio", busRdData, (8'hCB & 8'h96) | 8'h34);

    // R11
    levelMode = 1; #1;
    check("R11 mode1", levelSel, 8'h18);
    levelMode = 0; #1;
    check("R11 mode0", levelSel, 8'h00);

    // R6: full override to input leaves stored dir
    writeReg(1, 8'h00);
    periphSel = 8'hFF; periphOe = 8'h00;
    @(negedge clk);
    check("R5 force input", pinOe, 8'h00);
    readReg(1);
    check("R6 dir kept", busRdData, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule